// File: doc/BRIEF.md
# Adaptive Output Channel Selector

This block makes the output choice for an adaptive router. Every cycle it can take one packet header request. The routing logic supplies a mask of permitted output channels across P physical ports, each carrying V virtual channels. Flow control supplies a mask of the channels that are currently free. When at least one channel is both permitted and free, the block grants exactly one physical port and one virtual channel on it. Otherwise it issues nothing.

The choice is made in two steps. First the block picks a physical port. Among ports that offer a permitted free virtual channel, it prefers the one with the fewest virtual channels in use. Among equally loaded ports, it prefers the one granted longest ago. Second, on that port it takes the lowest-numbered permitted free virtual channel. Load and recency are tracked inside the block from its own grants and from release pulses. Nothing about topology or the routing rule is assumed.

Channel bit index for port p, virtual channel v is p*V+v, in every mask.

Top module: `out_chan_sel`

## Requirements
- R1: When req_valid is low, or no bit is set in both legal_mask and free_mask, grant_valid is low in the following cycle.
- R2: A request with at least one channel set in both masks yields grant_valid high in the next cycle, for one cycle, naming a channel (grant_port, grant_vc) that was set in both masks.
- R3: The granted port has the fewest active virtual channels among ports that offer a candidate channel.
- R4: Ties on load go to the port granted longest ago. After reset the recency order, oldest first, is port 0, 1, ..., P-1.
- R5: A granted port becomes the most recently used port, whether or not its load changes.
- R6: On the granted port, the lowest-index virtual channel set in both masks is granted.
- R7: A grant marks its channel active, and a release_mask bit clears that channel's active mark at the next edge. Releasing a channel that is not active has no effect. A grant and a release in the same cycle both take effect.
- R8: Reset clears grant_valid and all active marks, and restores the reset recency order.
- R9: A port whose channels are legal but not free, or free but not legal, is not a candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A header wants an output this cycle |
| legal_mask | input | P*V | Channels the routing logic permits |
| free_mask | input | P*V | Channels currently free for allocation |
| release_mask | input | P*V | One-cycle pulses ending use of a channel |
| grant_valid | output | 1 | One-cycle grant indication |
| grant_port | output | max(1,clog2 P) | Granted physical port |
| grant_vc | output | max(1,clog2 V) | Granted virtual channel on that port |

## Verification
The selector is driven with requests whose only candidates sit on ports of differing load, which separates load-first choice from recency choice. All-ports-open requests are issued once every port carries equal load, which exposes the recency order and its update after each grant. Masks where legal and free bits fall on different ports check that candidates need both. Release pulses, including one for a channel never granted and one coinciding with a grant, show whether load counting tracks real use, and a mid-run reset shows that both load and recency return to their initial state.

// File: rtl/ocs_pkg.sv
package ocs_pkg;
    // Index width that stays at least one bit for degenerate counts
    function automatic int unsigned idx_w(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/ocs_usage.sv
module ocs_usage #(
    parameter int unsigned P = 5,
    parameter int unsigned V = 2,
    localparam int unsigned NCH = P * V,
    localparam int unsigned PW = ocs_pkg::idx_w(P),
    localparam int unsigned VW = ocs_pkg::idx_w(V),
    localparam int unsigned CW = ocs_pkg::idx_w(V + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [PW-1:0]     set_port,
    input  logic [VW-1:0]     set_vc,
    input  logic [NCH-1:0]    rel_mask,
    output logic [P*CW-1:0]   load_flat
);
    typedef struct packed {
        logic [NCH-1:0] act;
    } use_t;

    use_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.act = st_q.act & ~rel_mask;
        for (int p = 0; p < int'(P); p++) begin
            for (int v = 0; v < int'(V); v++) begin
                if (set_en && set_port == PW'(p) && set_vc == VW'(v)) begin
                    st_d.act[p*V + v] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gp = 0; gp < P; gp++) begin : g_load
        logic [CW-1:0] cnt;
        always_comb begin
            cnt = '0;
            for (int v = 0; v < int'(V); v++) begin
                cnt = cnt + CW'(st_q.act[gp*V + v]);
            end
        end
        assign load_flat[gp*CW +: CW] = cnt;
    end
endmodule

// File: rtl/ocs_lru.sv
module ocs_lru #(
    parameter int unsigned P = 5,
    localparam int unsigned PW = ocs_pkg::idx_w(P)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [PW-1:0]     upd_port,
    output logic [P*PW-1:0]   age_flat
);
    // Larger age means granted longer ago; ages form a permutation of 0..P-1
    typedef struct packed {
        logic [P-1:0][PW-1:0] age;
    } lru_t;

    lru_t st_d, st_q;
    logic [PW-1:0] sel_age;

    always_comb begin
        sel_age = '0;
        for (int i = 0; i < int'(P); i++) begin
            if (upd_port == PW'(i)) sel_age = st_q.age[i];
        end
    end

    always_comb begin
        st_d = st_q;
        if (upd) begin
            for (int i = 0; i < int'(P); i++) begin
                if (upd_port == PW'(i)) begin
                    st_d.age[i] = '0;
                end else if (st_q.age[i] < sel_age) begin
                    st_d.age[i] = st_q.age[i] + PW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(P); i++) begin
                st_q.age[i] <= PW'(int'(P) - 1 - i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar gi = 0; gi < P; gi++) begin : g_out
        assign age_flat[gi*PW +: PW] = st_q.age[gi];
    end
endmodule

// File: rtl/ocs_pick.sv
module ocs_pick #(
    parameter int unsigned P = 5,
    parameter int unsigned V = 2,
    localparam int unsigned NCH = P * V,
    localparam int unsigned PW = ocs_pkg::idx_w(P),
    localparam int unsigned VW = ocs_pkg::idx_w(V),
    localparam int unsigned CW = ocs_pkg::idx_w(V + 1)
) (
    input  logic [NCH-1:0]    legal_mask,
    input  logic [NCH-1:0]    free_mask,
    input  logic [P*CW-1:0]   load_flat,
    input  logic [P*PW-1:0]   age_flat,
    output logic              found,
    output logic [PW-1:0]     sel_port,
    output logic [VW-1:0]     sel_vc
);
    logic [NCH-1:0] cand;
    logic [P-1:0]   port_has;
    logic [CW-1:0]  best_load;
    logic [PW-1:0]  best_age;
    logic           vc_found;

    assign cand = legal_mask & free_mask;

    for (genvar gp = 0; gp < P; gp++) begin : g_has
        assign port_has[gp] = |cand[gp*V +: V];
    end

    // Physical step: least load first, then oldest grant
    always_comb begin
        found     = 1'b0;
        sel_port  = '0;
        best_load = '0;
        best_age  = '0;
        for (int p = 0; p < int'(P); p++) begin
            if (port_has[p]) begin
                if (!found
                    || load_flat[p*CW +: CW] < best_load
                    || (load_flat[p*CW +: CW] == best_load
                        && age_flat[p*PW +: PW] > best_age)) begin
                    found     = 1'b1;
                    sel_port  = PW'(p);
                    best_load = load_flat[p*CW +: CW];
                    best_age  = age_flat[p*PW +: PW];
                end
            end
        end
    end

    // Virtual step: lowest index candidate on the chosen port
    always_comb begin
        sel_vc   = '0;
        vc_found = 1'b0;
        for (int p = 0; p < int'(P); p++) begin
            for (int v = 0; v < int'(V); v++) begin
                if (sel_port == PW'(p) && cand[p*V + v] && !vc_found) begin
                    sel_vc   = VW'(v);
                    vc_found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/out_chan_sel.sv
module out_chan_sel #(
    parameter int unsigned P = 5,
    parameter int unsigned V = 2,
    localparam int unsigned NCH = P * V,
    localparam int unsigned PW = ocs_pkg::idx_w(P),
    localparam int unsigned VW = ocs_pkg::idx_w(V),
    localparam int unsigned CW = ocs_pkg::idx_w(V + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [NCH-1:0]    legal_mask,
    input  logic [NCH-1:0]    free_mask,
    input  logic [NCH-1:0]    release_mask,
    output logic              grant_valid,
    output logic [PW-1:0]     grant_port,
    output logic [VW-1:0]     grant_vc
);
    typedef struct packed {
        logic          vld;
        logic [PW-1:0] port;
        logic [VW-1:0] vc;
    } grant_t;

    grant_t        gr_d, gr_q;
    logic [P*CW-1:0] load_flat;
    logic [P*PW-1:0] age_flat;
    logic          found;
    logic [PW-1:0] pick_port;
    logic [VW-1:0] pick_vc;
    logic          take;

    ocs_pick #(.P(P), .V(V)) u_pick (
        .legal_mask (legal_mask),
        .free_mask  (free_mask),
        .load_flat  (load_flat),
        .age_flat   (age_flat),
        .found      (found),
        .sel_port   (pick_port),
        .sel_vc     (pick_vc)
    );

    assign take = req_valid & found;

    ocs_usage #(.P(P), .V(V)) u_usage (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (take),
        .set_port  (pick_port),
        .set_vc    (pick_vc),
        .rel_mask  (release_mask),
        .load_flat (load_flat)
    );

    ocs_lru #(.P(P)) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (take),
        .upd_port (pick_port),
        .age_flat (age_flat)
    );

    always_comb begin
        gr_d      = gr_q;
        gr_d.vld  = take;
        gr_d.port = take ? pick_port : '0;
        gr_d.vc   = take ? pick_vc : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gr_q <= '0;
        end else begin
            gr_q <= gr_d;
        end
    end

    assign grant_valid = gr_q.vld;
    assign grant_port  = gr_q.port;
    assign grant_vc    = gr_q.vc;
endmodule

// File: rtl/out_chan_sel_chk.sv
module out_chan_sel_chk #(
    parameter int unsigned P = 5,
    parameter int unsigned V = 2,
    localparam int unsigned NCH = P * V,
    localparam int unsigned PW = ocs_pkg::idx_w(P),
    localparam int unsigned VW = ocs_pkg::idx_w(V),
    localparam int unsigned CW = ocs_pkg::idx_w(V + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [NCH-1:0]    legal_mask,
    input logic [NCH-1:0]    free_mask,
    input logic              grant_valid,
    input logic [PW-1:0]     grant_port,
    input logic [VW-1:0]     grant_vc,
    input logic [P*CW-1:0]   load_flat
);
    logic [NCH-1:0]  cand_q;
    logic [P*CW-1:0] load_q;
    logic            chosen_ok;
    logic            lower_hit;
    logic            better_hit;
    logic [CW-1:0]   chosen_load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            load_q <= '0;
        end else begin
            cand_q <= legal_mask & free_mask;
            load_q <= load_flat;
        end
    end

    always_comb begin
        chosen_ok   = 1'b0;
        lower_hit   = 1'b0;
        chosen_load = '0;
        for (int p = 0; p < int'(P); p++) begin
            if (grant_port == PW'(p)) begin
                chosen_load = load_q[p*CW +: CW];
                for (int v = 0; v < int'(V); v++) begin
                    if (grant_vc == VW'(v) && cand_q[p*V + v]) chosen_ok = 1'b1;
                    if (VW'(v) < grant_vc && cand_q[p*V + v]) lower_hit = 1'b1;
                end
            end
        end
    end

    always_comb begin
        better_hit = 1'b0;
        for (int p = 0; p < int'(P); p++) begin
            if ((|cand_q[p*V +: V]) && load_q[p*CW +: CW] < chosen_load) better_hit = 1'b1;
        end
    end

    // R1
    no_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || (legal_mask & free_mask) == '0) |=> !grant_valid);

    // R2
    issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (legal_mask & free_mask) != '0) |=> grant_valid);

    // R2
    grant_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> chosen_ok);

    // R6
    low_vc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !lower_hit);

    // R3
    min_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !better_hit);
endmodule

bind out_chan_sel out_chan_sel_chk #(.P(P), .V(V)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .legal_mask  (legal_mask),
    .free_mask   (free_mask),
    .grant_valid (grant_valid),
    .grant_port  (grant_port),
    .grant_vc    (grant_vc),
    .load_flat   (load_flat)
);

// File: tb/out_chan_sel_bench.sv
module out_chan_sel_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [9:0] legal_mask = '0;
    logic [9:0] free_mask = '0;
    logic [9:0] release_mask = '0;
    logic       grant_valid;
    logic [2:0] grant_port;
    logic [0:0] grant_vc;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    out_chan_sel #(.P(5), .V(2)) u_out_chan_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .legal_mask   (legal_mask),
        .free_mask    (free_mask),
        .release_mask (release_mask),
        .grant_valid  (grant_valid),
        .grant_port   (grant_port),
        .grant_vc     (grant_vc)
    );

    // {req, legal, free, release, exp_valid, exp_port, exp_vc, req_tag}
    // bit for port p, vc v is 2p+v
    localparam logic [39:0] TBL [0:NVEC-1] = '{
        {1'b1, 10'h3FF, 10'h3FF, 10'h000, 1'b1, 3'd0, 1'b0, 4'd4}, // R4 reset order: port 0 oldest
        {1'b1, 10'h00F, 10'h3FF, 10'h000, 1'b1, 3'd1, 1'b0, 4'd3}, // R3 p1 idle beats p0
        {1'b1, 10'h00A, 10'h3FF, 10'h000, 1'b1, 3'd0, 1'b1, 4'd4}, // R4 equal load, p0 older
        {1'b1, 10'h0F0, 10'h140, 10'h000, 1'b1, 3'd3, 1'b0, 4'd9}, // R9 p2 not free, p4 not legal
        {1'b1, 10'h3FF, 10'h000, 10'h000, 1'b0, 3'd0, 1'b0, 4'd1}, // R1 nothing free
        {1'b0, 10'h3FF, 10'h3FF, 10'h000, 1'b0, 3'd0, 1'b0, 4'd1}, // R1 no request
        {1'b1, 10'h030, 10'h020, 10'h000, 1'b1, 3'd2, 1'b1, 4'd6}, // R6 only vc1 free on p2
        {1'b1, 10'h203, 10'h3FF, 10'h000, 1'b1, 3'd4, 1'b1, 4'd3}, // R3 p4 load 0 vs p0 load 2
        {1'b0, 10'h000, 10'h000, 10'h003, 1'b0, 3'd0, 1'b0, 4'd7}, // R7 release both p0 vcs
        {1'b1, 10'h00A, 10'h3FF, 10'h000, 1'b1, 3'd0, 1'b1, 4'd7}, // R7 p0 back to load 0
        {1'b0, 10'h000, 10'h000, 10'h140, 1'b0, 3'd0, 1'b0, 4'd7}, // R7 release p3v0, idle p4v0
        {1'b1, 10'h180, 10'h3FF, 10'h000, 1'b1, 3'd3, 1'b1, 4'd7}, // R7 p4 still load 1
        {1'b1, 10'h3FF, 10'h3FF, 10'h000, 1'b1, 3'd1, 1'b0, 4'd5}, // R5 all load 1, p1 oldest
        {1'b1, 10'h3FF, 10'h3FF, 10'h000, 1'b1, 3'd2, 1'b0, 4'd5}, // R5 p1 moved to newest
        {1'b1, 10'h3FF, 10'h3FF, 10'h000, 1'b1, 3'd4, 1'b0, 4'd3}, // R3 p2 now load 2
        {1'b1, 10'h3FF, 10'h3FF, 10'h002, 1'b1, 3'd0, 1'b0, 4'd7}  // R7 grant with release
    };

    task automatic check(input int tag, input logic ev, input logic [2:0] ep, input logic ec);
        logic ok;
        checks++;
        ok = (grant_valid === ev) && (!ev || (grant_port === ep && grant_vc === ec));
        if (!ok) begin
            fails++;
            $display("FAIL R%0d: got v=%0b p=%0d c=%0d, expected v=%0b p=%0d c=%0d",
                     tag, grant_valid, grant_port, grant_vc, ev, ep, ec);
        end
    endtask

    task automatic apply(input logic rq, input logic [9:0] lg, input logic [9:0] fr,
                         input logic [9:0] rl);
        req_valid    = rq;
        legal_mask   = lg;
        free_mask    = fr;
        release_mask = rl;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired (R2)");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(8, 1'b0, 3'd0, 1'b0); // R8 idle while in reset
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i][39], TBL[i][38:29], TBL[i][28:19], TBL[i][18:9]);
            check(int'(TBL[i][3:0]), TBL[i][8], TBL[i][7:5], TBL[i][4]);
        end

        // R2 grant lasts one cycle only
        apply(1'b0, 10'h3FF, 10'h3FF, 10'h000);
        check(2, 1'b0, 3'd0, 1'b0);

        // R8 mid-run reset clears loads and recency
        rst_n = 1'b0;
        apply(1'b1, 10'h3FF, 10'h3FF, 10'h000);
        check(8, 1'b0, 3'd0, 1'b0);
        apply(1'b0, 10'h000, 10'h000, 10'h000);
        rst_n = 1'b1;
        apply(1'b1, 10'h3FF, 10'h3FF, 10'h000);
        check(8, 1'b1, 3'd0, 1'b0);
        apply(1'b1, 10'h00F, 10'h3FF, 10'h000);
        check(8, 1'b1, 3'd1, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule